// File: doc/BRIEF.md
# Two-wire register slave with 16-bit word registers

This block sits on a two-wire serial bus as a slave device and gives a bus master access to a small bank of 16-bit control registers. Each register has an 8-bit index. Two strap inputs pick one of four device addresses. The bus moves bytes, so every register word travels as two bytes, upper byte first. A register changes only once its whole word has arrived. After each complete word the index moves on by one, so a master can stream a run of consecutive registers in one transaction.

A read uses the combined format. The master first writes the register index, then issues a repeated start with the read address and clocks the data out. A master that can only send single bytes can still update a register. It writes the upper byte to the target index, then sends the lower byte to the bytewise index 0xF0, which commits the full word to the target. The rest of the chip reads any register through a parallel, combinational read port.

The two bus lines pass through a synchronizer before any edge is detected, so the system clock must run much faster than the bus clock. The data line is driven open-drain: the block only ever pulls it low.

Top module: `twr_top`

## Requirements
- R1: The device acknowledges the 8-bit write address selected by `adr_sel` and ignores the other three. The mapping is `adr_sel`=0 to 0x90, 1 to 0x98, 2 to 0xB0 and 3 to 0xB8. The matching read address, the same value with bit 0 set, is also acknowledged.
- R2: A device address that does not match is not acknowledged. Every later byte up to the next start is also unacknowledged and changes no register.
- R3: In a write, the first byte after the address is the register index, followed by data bytes with the upper byte first. Every byte is acknowledged. A register shows no change after only its upper byte has arrived, and takes the full word once the lower byte is received.
- R4: In a write, the index increments by one after each complete word. A run of N words starting at index k fills registers k to k+N-1.
- R5: After an index write, a repeated start and the read address, the device returns the addressed word upper byte first. While the master acknowledges, it continues with the following registers, the index incrementing after each word.
- R6: A no-acknowledge from the master after a data byte ends the read. The device then leaves SDA released, so every further bit reads 1 until the next start.
- R7: When a data byte is written to index 0xF0 while an upper byte is pending, {pending upper byte, this byte} is committed to the index that received the upper byte. The target register is unchanged until then. A byte written to 0xF0 with no upper byte pending changes nothing.
- R8: A start or stop condition at any bit position aborts the transfer in progress and discards the partial byte. After a start, the next byte is decoded as a device address.
- R9: With `NUM_REGS` registers, a write to an index at or above `NUM_REGS` (0x20 and 0xF0 with the default of 16) changes no register, and a read of such an index returns 0 on the bus and on the parallel port.
- R10: `sda_oe` changes only while SCL is low.
- R11: After reset, every register reads 0 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| adr_sel | input | 2 | Device-address strap select |
| host_idx | input | 8 | Parallel read port register index |
| host_data | output | 16 | Parallel read port register value (0 above the bank) |

## Verification
The hardest cases to reach are the ones that depend on what happened before the current transaction. A bytewise commit needs an upper byte left pending by an earlier transfer. A start or stop arriving in the middle of a byte must leave that byte pending or discarded. The bench reaches these by building the bus traffic bit by bit. It cuts byte tasks short after a few bits to issue a start or stop, and it inspects registers through the parallel port between the two halves of a word and between the transactions of a bytewise update. A sweep over all strap settings and addresses, and a streamed write and read-back of the whole bank against an arithmetic pattern, cover address decoding and index increment.

// File: rtl/twr_pkg.sv
// Package: shared types and constants for the two-wire register slave.
// Assumes 8-bit bus transfers, 8-bit register indices and 16-bit words.
package twr_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;
    localparam logic [IDX_W-1:0] BYTEWISE_IDX = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } twr_state_e;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_INDEX,
        RL_DATA
    } twr_role_e;

    // 7-bit device address from the two straps: 0x48, 0x4C, 0x58, 0x5C
    function automatic logic [6:0] dev_addr(input logic [1:0] sel);
        return {2'b10, sel[1], 1'b1, sel[0], 2'b00};
    endfunction
endpackage

// File: rtl/twr_linesync.sv
// Module: twr_linesync
// Synchronizes SCL and SDA into clk and flags clock edges and
// start/stop conditions. Assumes clk is far faster than SCL so both
// lines are seen in a consistent order. Resets to the idle-high bus.
module twr_linesync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic scl_d, sda_d, scl_s;

    // Shift both lines through the synchronizer and keep one history bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_in};
            scl_d  <= scl_ff[SYNC_STAGES-1];
            sda_d  <= sda_ff[SYNC_STAGES-1];
        end
    end

    // Decode edges and bus conditions from current and previous samples
    always_comb begin
        scl_s     = scl_ff[SYNC_STAGES-1];
        sda_s     = sda_ff[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/twr_regbank.sv
// Module: twr_regbank
// Bank of NUM_REGS word registers with one write port and two
// combinational read ports. Indices at or above NUM_REGS read as zero
// and drop writes. Assumes NUM_REGS is a power of two no larger than 256.
module twr_regbank
    import twr_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  a_idx,
    output logic [WORD_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [WORD_W-1:0] b_data
);
    localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [WORD_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Load one register on a full-word write that targets it
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                regs[g] <= wr_data;
        end
    end

    // Both read ports return zero for indices outside the bank
    always_comb begin
        a_data = ({1'b0, a_idx} < (IDX_W+1)'(NUM_REGS)) ? regs[a_idx[AW-1:0]] : '0;
        b_data = ({1'b0, b_idx} < (IDX_W+1)'(NUM_REGS)) ? regs[b_idx[AW-1:0]] : '0;
    end
endmodule

// File: rtl/twr_engine.sv
// Module: twr_engine
// Bit and byte protocol engine: device address match, index capture,
// paired-byte writes with auto-increment, bytewise commit through
// index 0xF0, and word reads. Assumes synchronized edge strobes from
// twr_linesync; start and stop override any state.
module twr_engine
    import twr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        adr_sel,
    input  logic [WORD_W-1:0] rd_word,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data,
    output logic              sda_oe,
    output twr_state_e        st_o,
    output twr_role_e         role_o,
    output logic [3:0]        cnt_o
);
    twr_state_e        state;
    twr_role_e         role;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] rx_sr, tx_sr, lo_keep, pend_hi;
    logic [IDX_W-1:0]  idx, pend_idx;
    logic              ack_bit, wphase, rphase, pend_valid, read_mode, mack_ok;
    logic              rx_done;

    // Byte completion, commit decision and pad drive
    always_comb begin
        rx_done = (state == ST_RX) && scl_fall && (cnt == BITS_PER_BYTE)
                  && !start_det && !stop_det;
        wr_en   = rx_done && (role == RL_DATA) && pend_valid
                  && ((idx == BYTEWISE_IDX) || wphase);
        wr_idx  = pend_idx;
        wr_data = {pend_hi, rx_sr};
        sda_oe  = ((state == ST_ACK) && ack_bit) || ((state == ST_TX) && !tx_sr[BYTE_W-1]);
        rd_idx  = idx;
        st_o    = state;
        role_o  = role;
        cnt_o   = cnt;
    end

    // Protocol state machine; start and stop take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            role       <= RL_ADDR;
            cnt        <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            lo_keep    <= '0;
            pend_hi    <= '0;
            pend_idx   <= '0;
            idx        <= '0;
            ack_bit    <= 1'b0;
            wphase     <= 1'b0;
            rphase     <= 1'b0;
            pend_valid <= 1'b0;
            read_mode  <= 1'b0;
            mack_ok    <= 1'b0;
        end else if (start_det) begin
            state     <= ST_RX;
            role      <= RL_ADDR;
            cnt       <= '0;
            read_mode <= 1'b0;
            ack_bit   <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            ack_bit <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        rx_sr <= {rx_sr[BYTE_W-2:0], sda_s};
                        cnt   <= cnt + 4'd1;
                    end else if (rx_done) begin
                        cnt     <= '0;
                        state   <= ST_ACK;
                        ack_bit <= 1'b1;
                        case (role)
                            RL_ADDR: begin
                                if (rx_sr[BYTE_W-1:1] == dev_addr(adr_sel)) begin
                                    read_mode <= rx_sr[0];
                                    role      <= RL_INDEX;
                                end else begin
                                    state   <= ST_IGNORE;
                                    ack_bit <= 1'b0;
                                end
                            end
                            RL_INDEX: begin
                                idx    <= rx_sr;
                                wphase <= 1'b0;
                                role   <= RL_DATA;
                            end
                            default: begin
                                if (idx == BYTEWISE_IDX) begin
                                    pend_valid <= 1'b0;
                                end else if (!wphase) begin
                                    pend_hi    <= rx_sr;
                                    pend_idx   <= idx;
                                    pend_valid <= 1'b1;
                                    wphase     <= 1'b1;
                                end else begin
                                    pend_valid <= 1'b0;
                                    wphase     <= 1'b0;
                                    idx        <= idx + 8'd1;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt     <= '0;
                        ack_bit <= 1'b0;
                        if (read_mode) begin
                            tx_sr   <= rd_word[WORD_W-1:BYTE_W];
                            lo_keep <= rd_word[BYTE_W-1:0];
                            rphase  <= 1'b0;
                            state   <= ST_TX;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (cnt == BITS_PER_BYTE) begin
                            state <= ST_MACK;
                            cnt   <= '0;
                            if (rphase)
                                idx <= idx + 8'd1;
                        end else begin
                            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mack_ok <= !sda_s;
                    end else if (scl_fall) begin
                        cnt <= '0;
                        if (!mack_ok) begin
                            state <= ST_IGNORE;
                        end else if (!rphase) begin
                            tx_sr  <= lo_keep;
                            rphase <= 1'b1;
                            state  <= ST_TX;
                        end else begin
                            tx_sr   <= rd_word[WORD_W-1:BYTE_W];
                            lo_keep <= rd_word[BYTE_W-1:0];
                            rphase  <= 1'b0;
                            state   <= ST_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/twr_top.sv
// Module: twr_top
// Two-wire bus slave fronting a bank of 16-bit registers, with a
// parallel read port for on-chip consumers. Assumes clk runs at least
// about ten times the SCL rate; SDA is open-drain through sda_oe.
module twr_top
    import twr_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [1:0]        adr_sel,
    input  logic [IDX_W-1:0]  host_idx,
    output logic [WORD_W-1:0] host_data
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx, eng_idx;
    logic [WORD_W-1:0] wr_data, eng_word;
    twr_state_e        eng_st;
    twr_role_e         eng_role;
    logic [3:0]        eng_cnt;

    twr_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twr_engine u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .adr_sel(adr_sel), .rd_word(eng_word), .rd_idx(eng_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe),
        .st_o(eng_st), .role_o(eng_role), .cnt_o(eng_cnt)
    );

    twr_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .a_idx(eng_idx), .a_data(eng_word),
        .b_idx(host_idx), .b_data(host_data)
    );
endmodule

// File: rtl/twr_checker.sv
// Module: twr_checker
// Protocol properties of twr_top, attached by bind below. Assumes the
// bus is slow against clk, as twr_top itself requires.
module twr_checker
    import twr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sda_oe,
    input logic       wr_en,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input twr_state_e st,
    input twr_role_e  role,
    input logic [3:0] cnt
);
    // R10: the data line drive moves only while the raw clock line is low
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_in);

    // R3: a register commit lines up with a falling clock edge seen by the synchronizer
    a_r3_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> scl_fall);

    // R8: a start sends the engine back to decoding a device address
    a_r8_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_RX && role == RL_ADDR && cnt == 4'd0));

    // R8: a stop leaves the engine idle with the line released
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (st == ST_IDLE && !sda_oe));

    // R2: while ignoring the bus, the slave never pulls the data line
    a_r2_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> !sda_oe);
endmodule

bind twr_top twr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
    .wr_en(wr_en), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .st(eng_st), .role(eng_role), .cnt(eng_cnt)
);

// File: tb/sim_twr_top.sv
module sim_twr_top;
    localparam int Q  = 5;
    localparam int NR = 16;
    localparam logic [7:0] DEV = 8'hB0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [1:0] adr_sel = 2'd2;
    logic [7:0] host_idx = 8'd0;
    logic [15:0] host_data;
    logic sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    int oe_viol = 0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;
    logic all_ack;
    logic [15:0] model [NR];

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    twr_top u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .adr_sel(adr_sel), .host_idx(host_idx),
        .host_data(host_data)
    );

    // R10 monitor: drive changes while the clock line is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m)
            oe_viol = oe_viol + 1;
        oe_prev = sda_oe;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic waitq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic r);
        waitq; sda_m = b; waitq; scl_m = 1'b1; waitq; r = sda_line; waitq; scl_m = 1'b0;
    endtask

    task automatic bus_start;
        sda_m = 1'b1; waitq; scl_m = 1'b1; waitq; sda_m = 1'b0; waitq; scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        waitq; sda_m = 1'b0; waitq; scl_m = 1'b1; waitq; sda_m = 1'b1; waitq;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ak);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(b[i], r);
        bit_io(1'b1, r);
        ak = ~r;
    endtask

    task automatic sb(input logic [7:0] b);
        logic ak;
        send_byte(b, ak);
        all_ack = all_ack & ak;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic r;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, r);
            b = {b[6:0], r};
        end
        bit_io(~mack, r);
    endtask

    task automatic host_chk(input logic [7:0] idx, input logic [15:0] exp, input string tag);
        host_idx = idx;
        @(negedge clk);
        check(tag, {16'd0, host_data}, {16'd0, exp});
    endtask

    function automatic logic [7:0] dev_w(input int s);
        case (s)
            0: return 8'h90;
            1: return 8'h98;
            2: return 8'hB0;
            default: return 8'hB8;
        endcase
    endfunction

    initial begin
        logic ak, r;
        logic [7:0] rb, rb2;
        logic ones;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset contents and released line
        for (int i = 0; i < NR; i++) begin
            model[i] = 16'd0;
            host_chk(8'(i), 16'd0, "R11 reset value");
        end
        check("R11 sda_oe after reset", {31'd0, sda_oe}, 32'd0);

        // R1: strap sweep against all four addresses
        for (int s = 0; s < 4; s++) begin
            adr_sel = 2'(s);
            repeat (4) @(negedge clk);
            for (int a = 0; a < 4; a++) begin
                bus_start; send_byte(dev_w(a), ak); bus_stop;
                check("R1 write address ack", {31'd0, ak}, {31'd0, (a == s)});
            end
            bus_start; send_byte(dev_w(s) | 8'h01, ak);
            check("R1 read address ack", {31'd0, ak}, 32'd1);
            recv_byte(1'b0, rb); bus_stop;
        end
        adr_sel = 2'd2;
        repeat (4) @(negedge clk);

        // R2: foreign address, following bytes ignored
        all_ack = 1'b0;
        bus_start; send_byte(8'h90, ak); all_ack = ak;
        send_byte(8'h03, ak); all_ack = all_ack | ak;
        send_byte(8'h12, ak); all_ack = all_ack | ak;
        send_byte(8'h34, ak); all_ack = all_ack | ak;
        bus_stop;
        check("R2 no ack for foreign address", {31'd0, all_ack}, 32'd0);
        host_chk(8'd3, model[3], "R2 register untouched");

        // R3/R4: stream the whole bank from index 0
        all_ack = 1'b1;
        bus_start; sb(DEV); sb(8'd0);
        for (int i = 0; i < NR; i++) begin
            model[i] = 16'(40503 * (i + 1) + i);
            sb(model[i][15:8]); sb(model[i][7:0]);
        end
        bus_stop;
        check("R3 all write bytes acked", {31'd0, all_ack}, 32'd1);
        for (int i = 0; i < NR; i++) host_chk(8'(i), model[i], "R4 auto-increment write");

        // R3: half word invisible mid-transaction and after an early stop
        bus_start; sb(DEV); sb(8'd5); sb(8'hAB);
        host_chk(8'd5, model[5], "R3 upper byte alone not visible");
        sb(8'hCD); bus_stop;
        model[5] = 16'hABCD;
        host_chk(8'd5, model[5], "R3 full word committed");
        bus_start; sb(DEV); sb(8'd6); sb(8'h77); bus_stop;
        host_chk(8'd6, model[6], "R3 stop after upper byte");

        // R5: combined read of three words from index 2
        bus_start; sb(DEV); sb(8'd2); bus_start; sb(DEV | 8'h01);
        for (int w = 0; w < 3; w++) begin
            recv_byte(1'b1, rb); recv_byte(w != 2, rb2);
            check("R5 read word", {16'd0, rb, rb2}, {16'd0, model[2 + w]});
        end
        bus_stop;

        // R4/R5: read back the whole bank in one transaction
        bus_start; sb(DEV); sb(8'd0); bus_start; sb(DEV | 8'h01);
        for (int w = 0; w < NR; w++) begin
            recv_byte(1'b1, rb); recv_byte(w != NR - 1, rb2);
            check("R4 read increment", {16'd0, rb, rb2}, {16'd0, model[w]});
        end
        bus_stop;

        // R6: nack after the upper byte, line stays released
        bus_start; sb(DEV); sb(8'd4); bus_start; sb(DEV | 8'h01);
        recv_byte(1'b0, rb);
        check("R6 byte before nack", {24'd0, rb}, {24'd0, model[4][15:8]});
        ones = 1'b1;
        for (int i = 0; i < 9; i++) begin
            bit_io(1'b1, r);
            ones = ones & r;
        end
        bus_stop;
        check("R6 released after nack", {31'd0, ones}, 32'd1);

        // R7: bytewise update through index 0xF0
        bus_start; sb(DEV); sb(8'd9); sb(8'h02);
        bus_start; sb(DEV); sb(8'hF0);
        host_chk(8'd9, model[9], "R7 target unchanged before low byte");
        sb(8'h84); bus_stop;
        model[9] = 16'h0284;
        host_chk(8'd9, model[9], "R7 bytewise commit");
        bus_start; sb(DEV); sb(8'hF0); sb(8'h55); bus_stop;
        for (int i = 0; i < NR; i++) host_chk(8'(i), model[i], "R7 orphan low byte no effect");

        // R8: start in mid data byte, start in mid address, stop in mid byte
        bus_start; sb(DEV); sb(8'd7); sb(8'h12);
        bit_io(1'b1, r); bit_io(1'b0, r); bit_io(1'b1, r);
        bus_start; send_byte(DEV, ak);
        check("R8 address after restart acked", {31'd0, ak}, 32'd1);
        sb(8'd8); sb(8'hBE); sb(8'hEF); bus_stop;
        model[8] = 16'hBEEF;
        host_chk(8'd7, model[7], "R8 aborted word discarded");
        host_chk(8'd8, model[8], "R8 write after abort");
        bus_start;
        bit_io(1'b1, r); bit_io(1'b0, r); bit_io(1'b1, r); bit_io(1'b1, r);
        bus_start; send_byte(DEV, ak);
        check("R8 address after partial address", {31'd0, ak}, 32'd1);
        sb(8'd10); sb(8'h3C); sb(8'h3C); bus_stop;
        model[10] = 16'h3C3C;
        host_chk(8'd10, model[10], "R8 write after address abort");
        bus_start; sb(DEV); sb(8'd11); sb(8'h99);
        bit_io(1'b0, r); bit_io(1'b1, r);
        bus_stop;
        host_chk(8'd11, model[11], "R8 stop mid byte");

        // R9: indices beyond the bank
        bus_start; sb(DEV); sb(8'h20); sb(8'h77); sb(8'h77); bus_stop;
        bus_start; sb(DEV); sb(8'h20); bus_start; sb(DEV | 8'h01);
        recv_byte(1'b1, rb); recv_byte(1'b0, rb2); bus_stop;
        check("R9 bus read beyond bank", {16'd0, rb, rb2}, 32'd0);
        bus_start; sb(DEV); sb(8'hF0); bus_start; sb(DEV | 8'h01);
        recv_byte(1'b1, rb); recv_byte(1'b0, rb2); bus_stop;
        check("R9 bus read of 0xF0", {16'd0, rb, rb2}, 32'd0);
        host_chk(8'h20, 16'd0, "R9 host read beyond bank");
        host_chk(8'hF0, 16'd0, "R9 host read of 0xF0");
        for (int i = 0; i < NR; i++) host_chk(8'(i), model[i], "R9 no aliasing");

        check("R10 drive changes with SCL high", oe_viol, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R5 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule